// File: doc/BRIEF.md
# Dual-Port Synchronous Memory Core

This block is a two-port synchronous static memory. Each port runs on its own clock and has its own enable, write strobe, four byte-lane write enables, address, write data and output gating. Both ports may read or write any word on any cycle, including the same word. The storage is a behavioural register array. Address counting and bus-width conversion are left to neighbouring blocks.

Every port first captures its controls, address and write data in input registers on its clock's rising edge. Writes commit one edge later. A strap per port picks the read latency. In flow-through mode read data shows up after the capturing edge. In pipelined mode it passes through one more output register. When a port's enable is low at a capturing edge, the port powers down and its outputs stop driving. In pipelined mode the drivers come back one cycle later than in flow-through mode. The output enable is an asynchronous gate on the drivers only.

Top module: `dpsram_core`

## Requirements
- R1: With `ft_x_i`=1, the data of a read captured at edge k appears on `rdata_x_o` with `dq_oe_x_o`=1 right after edge k.
- R2: With `ft_x_i`=0, the same read appears only after edge k+1. After edge k the output is not yet driven unless an earlier read is draining.
- R3: A word written through either port can be read back through either port. Both ports can complete accesses to different words in the same cycle.
- R4: If one port reads a word in the same cycle that the other port's write to it is captured, the read returns the previous contents. A read captured one cycle later returns the new data.
- R5: Write-enable bit i (`be_x_i[i]`) selects data bits [9i+8:9i]. Lanes whose bit is 0 keep their stored value.
- R6: With `ft_x_i`=1, an edge that captures `ce_x_i`=0 turns the drivers off (`dq_oe_x_o`=0, `rdata_x_o`=0) after that edge. A read captured at the next edge drives again immediately.
- R7: With `ft_x_i`=0, after an edge that captures `ce_x_i`=0, the drivers are off one edge later. A read captured when the enable returns drives only after the following edge.
- R8: When `oe_x_i`=0 the outputs are undriven at once, without a clock edge. Raising it restores the pipelined data, which is left unchanged while the drivers are off.
- R9: A write access never drives the read outputs. In flow-through mode they are off after the capturing edge; in pipelined mode they are off one edge later.
- R10: During and right after reset, both ports have `dq_oe_x_o`=0 and `rdata_x_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_a_i | input | 1 | Port A clock |
| ce_a_i | input | 1 | Port A enable, active high |
| we_a_i | input | 1 | Port A write (1) or read (0) |
| be_a_i | input | 4 | Port A byte-lane write enables |
| addr_a_i | input | ADDR_W | Port A word address |
| wdata_a_i | input | 36 | Port A write data |
| oe_a_i | input | 1 | Port A asynchronous output enable |
| ft_a_i | input | 1 | Port A mode: 1 flow-through, 0 pipelined |
| rdata_a_o | output | 36 | Port A read data (0 when undriven) |
| dq_oe_a_o | output | 1 | Port A drivers active |
| clk_b_i | input | 1 | Port B clock |
| ce_b_i | input | 1 | Port B enable, active high |
| we_b_i | input | 1 | Port B write (1) or read (0) |
| be_b_i | input | 4 | Port B byte-lane write enables |
| addr_b_i | input | ADDR_W | Port B word address |
| wdata_b_i | input | 36 | Port B write data |
| oe_b_i | input | 1 | Port B asynchronous output enable |
| ft_b_i | input | 1 | Port B mode: 1 flow-through, 0 pipelined |
| rdata_b_o | output | 36 | Port B read data (0 when undriven) |
| dq_oe_b_o | output | 1 | Port B drivers active |

## Verification
The bench targets the same-word write/read collision. A design that commits writes at the capture edge would return the new word one cycle early. It checks the extra cycle of pipelined wake-up after a deselect; a shared output-valid path would wake both modes at the same time or leave the pipelined port dark. Partial lane writes are read back across ports, which exposes swapped lane slices or lanes that are cleared by mistake. Toggling the output enable between clock edges shows whether it is registered rather than asynchronous, or whether it flushes the pipelined data.

// File: rtl/dpsram_pkg.sv
package dpsram_pkg;
  localparam int unsigned LANE_W_DEF = 9;
  localparam int unsigned LANES_DEF  = 4;

  typedef enum logic {
    OUT_PIPE = 1'b0,
    OUT_FLOW = 1'b1
  } out_mode_e;
endpackage

// File: rtl/dpsram_bank.sv
// One storage bank, written by a single port, read at two addresses.
module dpsram_bank #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 4,
  localparam int unsigned DATA_W = LANE_W * LANES,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr0_i,
  input  logic [ADDR_W-1:0] raddr1_i,
  output logic [DATA_W-1:0] rdata0_o,
  output logic [DATA_W-1:0] rdata1_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata0_o[l*LANE_W +: LANE_W] = mem[raddr0_i];
    assign rdata1_o[l*LANE_W +: LANE_W] = mem[raddr1_i];
  end
endmodule

// File: rtl/dpsram_port.sv
// Per-port input capture, output stage and power-down gating.
module dpsram_port
  import dpsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              we_i,
  input  logic [LANES-1:0]  be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_i,
  input  logic              ft_i,
  input  logic [DATA_W-1:0] flow_data_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              wr_en_o,
  output logic [LANES-1:0]  be_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o
);
  logic              ce_q, we_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] out_q;
  logic              out_vld_q;
  logic              rd_act;
  logic              drive;
  out_mode_e         mode;

  assign mode   = out_mode_e'(ft_i);
  assign rd_act = ce_q & ~we_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q      <= 1'b0;
      we_q      <= 1'b0;
      be_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
    end else begin
      ce_q      <= ce_i;
      we_q      <= we_i;
      be_q      <= be_i;
      addr_q    <= addr_i;
      wdata_q   <= wdata_i;
      out_vld_q <= rd_act;
      if (rd_act) out_q <= flow_data_i;
    end
  end

  // oe_i only masks the drivers; out_q/out_vld_q keep running.
  assign drive     = oe_i & ((mode == OUT_FLOW) ? rd_act : out_vld_q);
  assign dq_oe_o   = drive;
  assign rdata_o   = drive ? ((mode == OUT_FLOW) ? flow_data_i : out_q) : '0;
  assign addr_q_o  = addr_q;
  assign wr_en_o   = ce_q & we_q;
  assign be_q_o    = be_q;
  assign wdata_q_o = wdata_q;

  a_r6_flow_powerdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ft_i && !ce_i) |=> (!dq_oe_o || !ft_i));

  a_r7_pipe_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ft_i && !ce_i) |=> ##1 (!dq_oe_o || ft_i));

  a_r9_flow_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ft_i && ce_i && we_i) |=> (!dq_oe_o || !ft_i));

  a_r9_pipe_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ft_i && ce_i && we_i) |=> ##1 (!dq_oe_o || ft_i));
endmodule

// File: rtl/dpsram_core.sv
// Two single-writer banks; stored word = bank_a ^ bank_b.
module dpsram_core
  import dpsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANE_W = LANE_W_DEF,
  parameter int unsigned LANES  = LANES_DEF,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              rst_ni,
  input  logic              clk_a_i,
  input  logic              ce_a_i,
  input  logic              we_a_i,
  input  logic [LANES-1:0]  be_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  logic [DATA_W-1:0] wdata_a_i,
  input  logic              oe_a_i,
  input  logic              ft_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  output logic              dq_oe_a_o,
  input  logic              clk_b_i,
  input  logic              ce_b_i,
  input  logic              we_b_i,
  input  logic [LANES-1:0]  be_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  input  logic [DATA_W-1:0] wdata_b_i,
  input  logic              oe_b_i,
  input  logic              ft_b_i,
  output logic [DATA_W-1:0] rdata_b_o,
  output logic              dq_oe_b_o
);
  logic [ADDR_W-1:0] addr_a_q, addr_b_q;
  logic              wr_a, wr_b;
  logic [LANES-1:0]  be_a_q, be_b_q;
  logic [DATA_W-1:0] wd_a_q, wd_b_q;
  logic [DATA_W-1:0] ka_at_a, ka_at_b, kb_at_a, kb_at_b;
  logic [DATA_W-1:0] flow_a, flow_b;

  assign flow_a = ka_at_a ^ kb_at_a;
  assign flow_b = ka_at_b ^ kb_at_b;

  dpsram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_a (
    .clk_i(clk_a_i), .rst_ni(rst_ni), .ce_i(ce_a_i), .we_i(we_a_i),
    .be_i(be_a_i), .addr_i(addr_a_i), .wdata_i(wdata_a_i), .oe_i(oe_a_i),
    .ft_i(ft_a_i), .flow_data_i(flow_a), .addr_q_o(addr_a_q), .wr_en_o(wr_a),
    .be_q_o(be_a_q), .wdata_q_o(wd_a_q), .rdata_o(rdata_a_o), .dq_oe_o(dq_oe_a_o)
  );

  dpsram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_b (
    .clk_i(clk_b_i), .rst_ni(rst_ni), .ce_i(ce_b_i), .we_i(we_b_i),
    .be_i(be_b_i), .addr_i(addr_b_i), .wdata_i(wdata_b_i), .oe_i(oe_b_i),
    .ft_i(ft_b_i), .flow_data_i(flow_b), .addr_q_o(addr_b_q), .wr_en_o(wr_b),
    .be_q_o(be_b_q), .wdata_q_o(wd_b_q), .rdata_o(rdata_b_o), .dq_oe_o(dq_oe_b_o)
  );

  dpsram_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank_a (
    .clk_i(clk_a_i), .we_i(wr_a), .be_i(be_a_q), .waddr_i(addr_a_q),
    .wdata_i(wd_a_q ^ kb_at_a), .raddr0_i(addr_a_q), .raddr1_i(addr_b_q),
    .rdata0_o(ka_at_a), .rdata1_o(ka_at_b)
  );

  dpsram_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_bank_b (
    .clk_i(clk_b_i), .we_i(wr_b), .be_i(be_b_q), .waddr_i(addr_b_q),
    .wdata_i(wd_b_q ^ ka_at_b), .raddr0_i(addr_a_q), .raddr1_i(addr_b_q),
    .rdata0_o(kb_at_a), .rdata1_o(kb_at_b)
  );

  a_r10_reset_quiet: assert property (@(posedge clk_a_i)
    !rst_ni |-> (!dq_oe_a_o && !dq_oe_b_o));
endmodule

// File: tb/dpsram_core_tb.sv
module dpsram_core_tb;
  localparam int AW = 8;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          ce_a = 0, we_a = 0, oe_a = 1, ft_a = 1;
  logic [3:0]    be_a = 4'hf;
  logic [AW-1:0] addr_a = '0;
  logic [DW-1:0] wd_a = '0;
  logic          ce_b = 0, we_b = 0, oe_b = 1, ft_b = 1;
  logic [3:0]    be_b = 4'hf;
  logic [AW-1:0] addr_b = '0;
  logic [DW-1:0] wd_b = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic          dq_a, dq_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [DW-1:0] D1    = 36'h123456789;
  localparam logic [DW-1:0] D2    = 36'hABCDEF012;
  localparam logic [DW-1:0] OLDW  = 36'h0F0F0F0F0;
  localparam logic [DW-1:0] NEWW  = 36'h5A5A5A5A5;
  localparam logic [DW-1:0] FULLW = 36'h111111111;
  localparam logic [DW-1:0] BYTEW = 36'h999999999;

  always #2 clk = ~clk;

  dpsram_core #(.ADDR_W(AW)) u_dut (
    .rst_ni(rst_n),
    .clk_a_i(clk), .ce_a_i(ce_a), .we_a_i(we_a), .be_a_i(be_a), .addr_a_i(addr_a),
    .wdata_a_i(wd_a), .oe_a_i(oe_a), .ft_a_i(ft_a), .rdata_a_o(rd_a), .dq_oe_a_o(dq_a),
    .clk_b_i(clk), .ce_b_i(ce_b), .we_b_i(we_b), .be_b_i(be_b), .addr_b_i(addr_b),
    .wdata_b_i(wd_b), .oe_b_i(oe_b), .ft_b_i(ft_b), .rdata_b_o(rd_b), .dq_oe_b_o(dq_b)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] o, input logic [DW-1:0] n,
                                          input logic [3:0] be);
    logic [DW-1:0] r = o;
    for (int i = 0; i < 4; i++) if (be[i]) r[i*9 +: 9] = n[i*9 +: 9];
    return r;
  endfunction

  task automatic t_reset();
    repeat (3) cyc();
    chk("R10 dq_oe_a in reset", {35'd0, dq_a}, '0);
    chk("R10 rdata_b in reset", rd_b, '0);
    rst_n = 1'b1;
    cyc();
    chk("R10 dq_oe_b after reset", {35'd0, dq_b}, '0);
  endtask

  task automatic t_flow();
    ft_a = 1; ft_b = 1;
    ce_a = 1; we_a = 1; addr_a = 3; wd_a = D1; be_a = 4'hf;
    ce_b = 1; we_b = 1; addr_b = 4; wd_b = D2; be_b = 4'hf;
    cyc();
    chk("R9 flow write leaves drivers off", {35'd0, dq_a}, '0);
    we_a = 0; addr_a = 4;
    we_b = 0; addr_b = 3;
    cyc();
    chk("R1 flow read latency port A", rd_a, D2);
    chk("R3 cross-port read port B", rd_b, D1);
    chk("R1 flow drivers on", {35'd0, dq_a}, 36'd1);
    ce_a = 0; ce_b = 0;
    cyc();
    chk("R6 flow powerdown", {35'd0, dq_a}, '0);
    chk("R6 flow powerdown data", rd_a, '0);
    ce_a = 1; addr_a = 3;
    cyc();
    chk("R6 flow wake immediate", rd_a, D1);
  endtask

  task automatic t_pipe();
    ft_a = 0; ce_a = 0;
    cyc(); cyc();
    ce_a = 1; we_a = 0; addr_a = 4;
    cyc();
    chk("R2 pipe not yet driven", {35'd0, dq_a}, '0);
    addr_a = 3;
    cyc();
    chk("R2 pipe read one cycle later", rd_a, D2);
    ce_a = 0;
    cyc();
    chk("R7 pipe drains last read", rd_a, D1);
    ce_a = 1; addr_a = 4;
    cyc();
    chk("R7 pipe off after deselect", {35'd0, dq_a}, '0);
    cyc();
    chk("R7 pipe wakes one cycle late", rd_a, D2);
  endtask

  task automatic t_oe();
    oe_a = 0; #1;
    chk("R8 oe low drops drivers", {35'd0, dq_a}, '0);
    chk("R8 oe low data zero", rd_a, '0);
    oe_a = 1; #1;
    chk("R8 oe restore keeps data", rd_a, D2);
    @(negedge clk);
    ce_a = 0; oe_a = 0;
    cyc();
    oe_a = 1; #1;
    chk("R8 pipeline advanced under oe low", rd_a, D2);
    cyc();
  endtask

  task automatic t_collide();
    ft_a = 1; ft_b = 1;
    ce_a = 1; we_a = 1; addr_a = 7; wd_a = OLDW; be_a = 4'hf;
    cyc();
    wd_a = NEWW;
    ce_b = 1; we_b = 0; addr_b = 7;
    cyc();
    chk("R4 same-cycle read returns old", rd_b, OLDW);
    ce_a = 0; we_a = 0;
    cyc();
    chk("R4 next-cycle read returns new", rd_b, NEWW);
    ce_b = 0;
  endtask

  task automatic t_bytes();
    ft_a = 1; ft_b = 1;
    ce_a = 1; we_a = 1; addr_a = 10; wd_a = FULLW; be_a = 4'hf;
    ce_b = 1; we_b = 1; addr_b = 11; wd_b = FULLW; be_b = 4'hf;
    cyc();
    wd_a = BYTEW; be_a = 4'b0101;
    wd_b = BYTEW; be_b = 4'b1000;
    cyc();
    we_a = 0; we_b = 0;
    cyc();
    chk("R5 port A lanes 0,2 written", rd_a, merge(FULLW, BYTEW, 4'b0101));
    chk("R5 port B lane 3 written", rd_b, merge(FULLW, BYTEW, 4'b1000));
    ce_b = 0; addr_a = 11;
    cyc();
    chk("R5 R3 port B lane write seen by A", rd_a, merge(FULLW, BYTEW, 4'b1000));
    ce_a = 0;
    cyc();
  endtask

  initial begin
    t_reset();
    t_flow();
    t_pipe();
    t_oe();
    t_collide();
    t_bytes();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule